// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller

This block is the coherence engine that sits beside one small direct-mapped cache in a shared-bus multiprocessor. Each cache line holds one data word, a tag and a line state of Invalid, Shared or Modified. The block serves load and store requests from its processor. It raises read-miss, write-miss and invalidate transactions on a shared snoop bus. It writes dirty victims back through a memory port, and it reacts to transactions that other caches place on the bus.

Two separate transition tables steer the line state. The processor-side table classifies each request as a read hit, a local write hit, an upgrade or a miss, and it flags a dirty victim that must be written back before the bus request goes out. The bus-side table decides, for each snooped transaction, whether the matching line is demoted or dropped and whether its dirty word is flushed. Only one miss or upgrade is outstanding at a time. The processor port is stalled until that transaction completes.

The bus never shows this cache its own transactions on the snoop input. Arbitration is outside the block: `bus_ack_i` marks the cycle in which the bus serves the request.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A load that hits a Shared or Modified line pulses `cpu_done_o` one cycle after acceptance with the cached word on `cpu_rdata_o`, with no bus request and no write-back.
- R2: A load that misses on an Invalid or clean line raises `bus_req_o` with op 2'b01 (read miss) and the request address, held until `bus_ack_i`. The word on `bus_rdata_i` is installed Shared and returned one cycle after the ack.
- R3: A load whose indexed line is Modified with another tag first raises `wb_valid_o` with the victim address and word, and raises the read miss only after `wb_ack_i`.
- R4: A store that hits a Shared line raises `bus_req_o` with op 2'b11 (invalidate). After the ack the line holds the store word and is Modified.
- R5: A store that hits a Modified line updates the word locally and pulses `cpu_done_o` one cycle after acceptance, with no bus request.
- R6: A store miss raises op 2'b10 (write miss) after any dirty-victim write-back, and installs the store word as Modified. `cpu_rdata_o` returns the line word after every access.
- R7: A snooped read miss on a Shared line, or any snooped transaction whose tag matches no valid line, produces no flush and leaves the line unchanged.
- R8: A snooped read miss (op 2'b01) on a Modified line pulses `flush_o` one cycle later with that address and word, and the line drops to Shared.
- R9: A snooped write miss (2'b10) or invalidate (2'b11) on a Shared line makes it Invalid without a flush.
- R10: A snooped write miss on a Modified line flushes the word one cycle later and makes the line Invalid.
- R11: `cpu_ready_o` is low while a write-back or bus request is outstanding, and at most one of `wb_valid_o` and `bus_req_o` is high.
- R12: `cpu_ready_o` is low in any cycle where `snp_valid_i` is high and the snoop index (address bits [IDX_W-1:0]) equals the processor index, so the snoop is applied first.
- R13: After reset every line is Invalid, and `cpu_ready_o` is high while `bus_req_o`, `wb_valid_o`, `flush_o` and `cpu_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Request word address |
| cpu_wdata_i | input | DATA_W | Store word |
| cpu_ready_o | output | 1 | Request accepted when high with cpu_req_i |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Line word after the access |
| bus_req_o | output | 1 | Bus transaction request |
| bus_op_o | output | 2 | 01 read miss, 10 write miss, 11 invalidate |
| bus_addr_o | output | ADDR_W | Bus transaction address |
| bus_ack_i | input | 1 | Bus served the request this cycle |
| bus_rdata_i | input | DATA_W | Fill word, valid with bus_ack_i |
| snp_valid_i | input | 1 | Snooped transaction from another cache |
| snp_op_i | input | 2 | Snooped op, same encoding as bus_op_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| flush_o | output | 1 | Dirty word driven on bus and to memory |
| flush_addr_o | output | ADDR_W | Flushed address |
| flush_data_o | output | DATA_W | Flushed word |
| wb_valid_o | output | 1 | Victim write-back request |
| wb_addr_o | output | ADDR_W | Victim address |
| wb_data_o | output | DATA_W | Victim word |
| wb_ack_i | input | 1 | Memory accepted the write-back |

## Verification
A table of processor accesses walks one line through Invalid, Shared and Modified: a cold load, a repeat load, a store to a clean line, a store to a dirty line and a load that evicts that dirty line. This separates the four processor-side outcomes and shows whether the write-back comes before the bus request. Directed snoops then send read misses, write misses and invalidates at Shared, Modified and tag-mismatched lines. The state they leave behind is read through the next processor access (hit, upgrade or miss) and through the flush port. A snoop to the same index as a waiting request tells the priority rule apart from a snoop to another index, and a reset after activity shows that every line is dropped.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_e;
  typedef enum logic [1:0] {BOP_NONE = 2'd0, BOP_RD = 2'd1, BOP_WR = 2'd2, BOP_INV = 2'd3} bus_op_e;
  typedef enum logic [1:0] {PA_HIT_RD, PA_HIT_WR, PA_UPGRADE, PA_MISS} proc_act_e;
  typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_BUS} fsm_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output line_st_e          ra_st_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output line_st_e          rb_st_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              pw_en_i,
  input  logic [IDX_W-1:0]  pw_idx_i,
  input  logic [TAG_W-1:0]  pw_tag_i,
  input  line_st_e          pw_st_i,
  input  logic              pw_data_en_i,
  input  logic [DATA_W-1:0] pw_data_i,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  line_st_e          sw_st_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic p_hit, s_hit;
    assign p_hit = pw_en_i && (pw_idx_i == IDX_W'(i));
    assign s_hit = sw_en_i && (sw_idx_i == IDX_W'(i));

    // processor-side fill wins: its bus transaction is the later one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i]   <= LS_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (p_hit) begin
        st_q[i]  <= pw_st_i;
        tag_q[i] <= pw_tag_i;
        if (pw_data_en_i) data_q[i] <= pw_data_i;
      end else if (s_hit) begin
        st_q[i] <= sw_st_i;
      end
    end
  end

  assign ra_st_o   = st_q[ra_idx_i];
  assign ra_tag_o  = tag_q[ra_idx_i];
  assign ra_data_o = data_q[ra_idx_i];
  assign rb_st_o   = st_q[rb_idx_i];
  assign rb_tag_o  = tag_q[rb_idx_i];
  assign rb_data_o = data_q[rb_idx_i];

  p_snoop_no_promote_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_i |-> (sw_st_i != LS_M))
    else $error("snoop side promoted a line");
endmodule

// File: rtl/msi_proc_side.sv
module msi_proc_side
  import msi_pkg::*;
(
  input  logic      we_i,
  input  line_st_e  st_i,
  input  logic      tag_eq_i,
  output proc_act_e act_o,
  output bus_op_e   op_o,
  output logic      victim_wb_o
);
  logic hit;
  assign hit = tag_eq_i && (st_i != LS_I);

  always_comb begin
    act_o       = PA_MISS;
    op_o        = we_i ? BOP_WR : BOP_RD;
    victim_wb_o = 1'b0;
    if (hit) begin
      if (!we_i)            act_o = PA_HIT_RD;
      else if (st_i == LS_M) act_o = PA_HIT_WR;
      else begin
        act_o = PA_UPGRADE;
        op_o  = BOP_INV;
      end
    end else begin
      victim_wb_o = (st_i == LS_M);
    end
  end
endmodule

// File: rtl/msi_bus_side.sv
module msi_bus_side
  import msi_pkg::*;
(
  input  logic     valid_i,
  input  bus_op_e  op_i,
  input  line_st_e st_i,
  input  logic     tag_eq_i,
  output logic     upd_o,
  output line_st_e nxt_o,
  output logic     flush_o
);
  logic hit;
  assign hit = valid_i && tag_eq_i && (st_i != LS_I);

  always_comb begin
    upd_o   = 1'b0;
    nxt_o   = st_i;
    flush_o = 1'b0;
    unique case (op_i)
      BOP_RD: if (hit && st_i == LS_M) begin
        upd_o   = 1'b1;
        nxt_o   = LS_S;
        flush_o = 1'b1;
      end
      BOP_WR, BOP_INV: if (hit) begin
        upd_o   = 1'b1;
        nxt_o   = LS_I;
        flush_o = (st_i == LS_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  input  logic              wb_ack_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx, req_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag, req_tag;
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  fsm_e              fsm_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  bus_op_e           bus_op_q;
  logic [ADDR_W-1:0] vic_addr_q;
  logic [DATA_W-1:0] vic_data_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              flush_q;
  logic [ADDR_W-1:0] flush_addr_q;
  logic [DATA_W-1:0] flush_data_q;

  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  // line store
  line_st_e          ra_st, rb_st;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  logic [DATA_W-1:0] ra_data, rb_data;
  logic              pw_en, pw_data_en;
  logic [IDX_W-1:0]  pw_idx;
  logic [TAG_W-1:0]  pw_tag;
  line_st_e          pw_st;
  logic [DATA_W-1:0] pw_data;
  logic              sw_en;
  line_st_e          sw_st;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .ra_idx_i(cpu_idx), .ra_st_o(ra_st), .ra_tag_o(ra_tag), .ra_data_o(ra_data),
    .rb_idx_i(snp_idx), .rb_st_o(rb_st), .rb_tag_o(rb_tag), .rb_data_o(rb_data),
    .pw_en_i(pw_en), .pw_idx_i(pw_idx), .pw_tag_i(pw_tag), .pw_st_i(pw_st),
    .pw_data_en_i(pw_data_en), .pw_data_i(pw_data),
    .sw_en_i(sw_en), .sw_idx_i(snp_idx), .sw_st_i(sw_st)
  );

  // processor-side table
  proc_act_e p_act;
  bus_op_e   p_op;
  logic      p_wb;
  msi_proc_side i_proc (
    .we_i(cpu_we_i), .st_i(ra_st), .tag_eq_i(ra_tag == cpu_tag),
    .act_o(p_act), .op_o(p_op), .victim_wb_o(p_wb)
  );

  // bus-side table
  logic s_flush;
  msi_bus_side i_bus (
    .valid_i(snp_valid_i), .op_i(bus_op_e'(snp_op_i)), .st_i(rb_st),
    .tag_eq_i(rb_tag == snp_tag), .upd_o(sw_en), .nxt_o(sw_st), .flush_o(s_flush)
  );

  // snoop to the same index goes first
  assign cpu_ready_o = (fsm_q == FS_IDLE) && !(snp_valid_i && (snp_idx == cpu_idx));

  logic accept;
  assign accept = cpu_req_i && cpu_ready_o;

  always_comb begin
    pw_en      = 1'b0;
    pw_idx     = cpu_idx;
    pw_tag     = cpu_tag;
    pw_st      = LS_I;
    pw_data_en = 1'b0;
    pw_data    = cpu_wdata_i;
    unique case (fsm_q)
      FS_IDLE: if (accept && p_act == PA_HIT_WR) begin
        pw_en      = 1'b1;
        pw_st      = LS_M;
        pw_data_en = 1'b1;
      end
      FS_WB: if (wb_ack_i) begin
        pw_en  = 1'b1;
        pw_idx = req_idx;
        pw_tag = vic_addr_q[ADDR_W-1:IDX_W];
        pw_st  = LS_I;
      end
      FS_BUS: if (bus_ack_i) begin
        pw_en      = 1'b1;
        pw_idx     = req_idx;
        pw_tag     = req_tag;
        pw_st      = (bus_op_q == BOP_RD) ? LS_S : LS_M;
        pw_data_en = 1'b1;
        pw_data    = (bus_op_q == BOP_RD) ? bus_rdata_i : req_wdata_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= FS_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      bus_op_q    <= BOP_NONE;
      vic_addr_q  <= '0;
      vic_data_q  <= '0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        FS_IDLE: if (accept) begin
          req_we_q    <= cpu_we_i;
          req_addr_q  <= cpu_addr_i;
          req_wdata_q <= cpu_wdata_i;
          bus_op_q    <= p_op;
          unique case (p_act)
            PA_HIT_RD: begin
              done_q  <= 1'b1;
              rdata_q <= ra_data;
            end
            PA_HIT_WR: begin
              done_q  <= 1'b1;
              rdata_q <= cpu_wdata_i;
            end
            PA_UPGRADE: fsm_q <= FS_BUS;
            default: begin
              vic_addr_q <= {ra_tag, cpu_idx};
              vic_data_q <= ra_data;
              fsm_q      <= p_wb ? FS_WB : FS_BUS;
            end
          endcase
        end
        FS_WB: if (wb_ack_i) fsm_q <= FS_BUS;
        FS_BUS: if (bus_ack_i) begin
          fsm_q   <= FS_IDLE;
          done_q  <= 1'b1;
          rdata_q <= (bus_op_q == BOP_RD) ? bus_rdata_i : req_wdata_q;
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q      <= 1'b0;
      flush_addr_q <= '0;
      flush_data_q <= '0;
    end else begin
      flush_q <= s_flush;
      if (s_flush) begin
        flush_addr_q <= snp_addr_i;
        flush_data_q <= rb_data;
      end
    end
  end

  assign cpu_done_o   = done_q;
  assign cpu_rdata_o  = rdata_q;
  assign bus_req_o    = (fsm_q == FS_BUS);
  assign bus_op_o     = bus_op_q;
  assign bus_addr_o   = req_addr_q;
  assign wb_valid_o   = (fsm_q == FS_WB);
  assign wb_addr_o    = vic_addr_q;
  assign wb_data_o    = vic_data_q;
  assign flush_o      = flush_q;
  assign flush_addr_o = flush_addr_q;
  assign flush_data_o = flush_data_q;

  p_one_outstanding_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_req_o, wb_valid_o}))
    else $error("write-back and bus request together");

  p_stall_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o || wb_valid_o) |-> !cpu_ready_o)
    else $error("processor port ready while busy");

  p_bus_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_op_o)))
    else $error("bus request dropped or changed before ack");

  p_wb_then_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ack_i) |=> bus_req_o)
    else $error("no bus request after victim write-back");

  p_done_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i) |=> (cpu_done_o && !bus_req_o))
    else $error("no completion after bus ack");
endmodule

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready_o, cpu_done_o;
  logic [31:0] cpu_rdata_o;
  logic        bus_req_o;
  logic [1:0]  bus_op_o;
  logic [15:0] bus_addr_o;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = '0;
  logic [15:0] snp_addr = '0;
  logic        flush_o;
  logic [15:0] flush_addr_o;
  logic [31:0] flush_data_o;
  logic        wb_valid_o;
  logic [15:0] wb_addr_o;
  logic [31:0] wb_data_o;
  logic        wb_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  msi_snoop_ctrl i_msi_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o, .cpu_done_o, .cpu_rdata_o,
    .bus_req_o, .bus_op_o, .bus_addr_o, .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .flush_o, .flush_addr_o, .flush_data_o,
    .wb_valid_o, .wb_addr_o, .wb_data_o, .wb_ack_i(wb_ack)
  );

  function automatic logic [31:0] mem_fn(input logic [15:0] a);
    return {16'hC0DE, a};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [1:0]  op;
    logic        wb;
    logic [15:0] wb_addr;
    logic [31:0] wb_data;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0010, 32'h0,        2'b01, 1'b0, 16'h0,    32'h0,        32'hC0DE0010}, // R2 cold load
    '{1'b0, 16'h0010, 32'h0,        2'b00, 1'b0, 16'h0,    32'h0,        32'hC0DE0010}, // R1 hit S
    '{1'b1, 16'h0010, 32'hAAAA0001, 2'b11, 1'b0, 16'h0,    32'h0,        32'hAAAA0001}, // R4 upgrade
    '{1'b1, 16'h0010, 32'hAAAA0002, 2'b00, 1'b0, 16'h0,    32'h0,        32'hAAAA0002}, // R5 local store
    '{1'b0, 16'h0010, 32'h0,        2'b00, 1'b0, 16'h0,    32'h0,        32'hAAAA0002}, // R1 hit M
    '{1'b0, 16'h0020, 32'h0,        2'b01, 1'b1, 16'h0010, 32'hAAAA0002, 32'hC0DE0020}, // R3 dirty victim
    '{1'b1, 16'h0031, 32'hBBBB0001, 2'b10, 1'b0, 16'h0,    32'h0,        32'hBBBB0001}, // R6 store miss
    '{1'b1, 16'h0041, 32'hBBBB0002, 2'b10, 1'b1, 16'h0031, 32'hBBBB0001, 32'hBBBB0002}, // R6 victim then WR
    '{1'b1, 16'h0022, 32'hCCCC0001, 2'b10, 1'b0, 16'h0,    32'h0,        32'hCCCC0001}, // R6 store miss
    '{1'b0, 16'h0020, 32'h0,        2'b00, 1'b0, 16'h0,    32'h0,        32'hC0DE0020}  // R1 hit S
  };

  task automatic do_cpu(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [1:0] eop, input logic ewb, input logic [15:0] ewa,
                        input logic [31:0] ewd, input logic [31:0] erd, input string rq);
    logic [1:0]  sop = 2'b00;
    logic [15:0] sadr = '0;
    logic        swb = 1'b0;
    logic [15:0] swa = '0;
    logic [31:0] swd = '0;
    logic        got = 1'b0;
    logic        stall_bad = 1'b0;
    logic        order_bad = 1'b0;
    logic [31:0] rd = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1 chk(rq, "ready at request", 32'(cpu_ready_o), 32'd1);
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (cpu_done_o) begin
        got = 1'b1;
        rd  = cpu_rdata_o;
      end else begin
        if (cpu_ready_o) stall_bad = 1'b1;
        if (wb_valid_o) begin
          swb = 1'b1; swa = wb_addr_o; swd = wb_data_o; wb_ack = 1'b1;
        end else if (bus_req_o) begin
          if (ewb && !swb) order_bad = 1'b1;
          sop = bus_op_o; sadr = bus_addr_o;
          bus_ack = 1'b1; bus_rdata = mem_fn(bus_addr_o);
        end
        @(negedge clk);
        wb_ack = 1'b0; bus_ack = 1'b0;
      end
    end
    chk(rq, "completed", 32'(got), 32'd1);
    chk(rq, "bus op", 32'(sop), 32'(eop));
    if (eop != 2'b00) chk(rq, "bus addr", 32'(sadr), 32'(a));
    chk(rq, "write-back seen", 32'(swb), 32'(ewb));
    if (ewb) begin
      chk(rq, "victim addr", 32'(swa), 32'(ewa));
      chk(rq, "victim data", swd, ewd);
      chk("R3", "write-back before bus", 32'(order_bad), 32'd0);
    end
    chk(rq, "rdata", rd, erd);
    chk("R11", "stalled while busy", 32'(stall_bad), 32'd0);
  endtask

  task automatic do_snoop(input logic [1:0] op, input logic [15:0] a, input logic eflush,
                          input logic [31:0] edata, input string rq);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(rq, "flush", 32'(flush_o), 32'(eflush));
    if (eflush) begin
      chk(rq, "flush addr", 32'(flush_addr_o), 32'(a));
      chk(rq, "flush data", flush_data_o, edata);
    end
  endtask

  task automatic check_idle(input string rq);
    chk(rq, "ready", 32'(cpu_ready_o), 32'd1);
    chk(rq, "bus_req", 32'(bus_req_o), 32'd0);
    chk(rq, "wb_valid", 32'(wb_valid_o), 32'd0);
    chk(rq, "flush", 32'(flush_o), 32'd0);
    chk(rq, "done", 32'(cpu_done_o), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_idle("R13");

    for (int i = 0; i < NV; i++)
      do_cpu(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].op, VEC[i].wb,
             VEC[i].wb_addr, VEC[i].wb_data, VEC[i].rdata, "R1-table");

    // R7: read snoop on Shared, and tag mismatch, change nothing
    do_snoop(2'b01, 16'h0020, 1'b0, 32'h0, "R7");
    do_snoop(2'b10, 16'h0030, 1'b0, 32'h0, "R7");
    do_cpu(1'b0, 16'h0020, 32'h0, 2'b00, 1'b0, 16'h0, 32'h0, 32'hC0DE0020, "R7");

    // R8: read snoop on Modified flushes and demotes to Shared
    do_snoop(2'b01, 16'h0041, 1'b1, 32'hBBBB0002, "R8");
    do_cpu(1'b1, 16'h0041, 32'hDDDD0001, 2'b11, 1'b0, 16'h0, 32'h0, 32'hDDDD0001, "R8");

    // R9: write-miss and invalidate snoops drop Shared lines
    do_snoop(2'b10, 16'h0020, 1'b0, 32'h0, "R9");
    do_cpu(1'b0, 16'h0020, 32'h0, 2'b01, 1'b0, 16'h0, 32'h0, 32'hC0DE0020, "R9");
    do_snoop(2'b11, 16'h0020, 1'b0, 32'h0, "R9");
    do_cpu(1'b0, 16'h0020, 32'h0, 2'b01, 1'b0, 16'h0, 32'h0, 32'hC0DE0020, "R9");

    // R10: write-miss snoop on Modified flushes and invalidates
    do_snoop(2'b10, 16'h0022, 1'b1, 32'hCCCC0001, "R10");
    do_cpu(1'b0, 16'h0022, 32'h0, 2'b01, 1'b0, 16'h0, 32'h0, 32'hC0DE0022, "R10");

    // R12: same-index snoop blocks the processor port
    @(negedge clk);
    cpu_addr = 16'h0020; cpu_req = 1'b0;
    snp_valid = 1'b1; snp_op = 2'b01; snp_addr = 16'h0070;
    #1 chk("R12", "ready with same-index snoop", 32'(cpu_ready_o), 32'd0);
    snp_addr = 16'h0071;
    #1 chk("R12", "ready with other-index snoop", 32'(cpu_ready_o), 32'd1);
    @(negedge clk);
    snp_valid = 1'b0;

    // R13: reset drops all lines
    do_reset();
    check_idle("R13");
    do_cpu(1'b0, 16'h0022, 32'h0, 2'b01, 1'b0, 16'h0, 32'h0, 32'hC0DE0022, "R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule